// File: doc/BRIEF.md
# Half-to-Single Precision Float Widener

This block turns a 16-bit binary floating-point operand (one sign bit, a 5-bit exponent biased by 15, a 10-bit fraction) into the 32-bit single-precision word (one sign bit, an 8-bit exponent biased by 127, a 23-bit fraction) that has exactly the same value. Every half-precision value is exactly representable in single precision, so the block does no rounding and raises no flags. It is placed in front of a single-precision datapath that reads operands stored in the narrow format.

Each encoding is sorted into zero, subnormal, normal, infinity or NaN. A subnormal input becomes a normal single: a one-cycle priority encoder finds the leading one of the fraction, and a barrel shifter moves it out as the hidden bit. A NaN keeps its payload in the upper fraction bits, and every newly created low fraction bit is filled with ones. A parameter selects whether the result and its valid strobe come straight from the logic or from an output register one cycle later.

Top module: `half_to_single_widen`

## Requirements
- R1: For a half input whose exponent field is between 1 and 30, the single exponent equals the half exponent plus 112. The 10 half fraction bits land in single bits 22..13, single bits 12..0 are zero, and the sign moves from half bit 15 to single bit 31.
- R2: A half input with exponent 0 and fraction 0 gives a single word whose only possibly set bit is bit 31, which is a copy of the input sign.
- R3: A half input with exponent 0 and a nonzero fraction becomes a normal single. Let n be the number of left shifts that bring the fraction's leading one to the hidden-bit position (n is 1 to 10). The exponent is 113 minus n, and the fraction is the shifted value with the leading one removed, placed in bits 22..13.
- R4: A half input with exponent 31 and fraction 0 gives exponent 255, a zero fraction and the input sign.
- R5: A half input with exponent 31 and a nonzero fraction gives exponent 255, the half fraction in bits 22..13, ones in bits 12..0 and the input sign.
- R6: For every finite half input, the single result has exactly the same numeric value as the input.
- R7: With the output register enabled (the default), out_valid equals the in_valid of the previous clock edge, and out_single carries the result of the operand presented with it. Reset clears out_valid and out_single.
- R8: With the output register enabled, out_single keeps its previous value after any clock edge at which in_valid was low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_half | input | 16 | Half-precision operand |
| out_valid | output | 1 | Result strobe |
| out_single | output | 32 | Single-precision result |

## Verification
All 65536 half encodings are applied in order, so every class is covered: both signed zeros, all 1023 subnormal fractions with each leading-one position, every normal exponent, both infinities, and every NaN payload. Finite values are checked against a reference that computes the number with real arithmetic and normalises it again. This catches errors in rebiasing, in the shift count and in the dropped hidden bit, none of which a bit-rule copy would reveal. NaNs are checked against the padding rule. Idle cycles placed between operands show whether the valid strobe follows with one cycle of latency and whether the held result stays unchanged.

// File: rtl/hcvt_pkg.sv
`timescale 1ns/1ps
package hcvt_pkg;
  localparam int H_EW = 5;
  localparam int H_FW = 10;
  localparam int S_EW = 8;
  localparam int S_FW = 23;
  localparam int H_W  = 1 + H_EW + H_FW;
  localparam int S_W  = 1 + S_EW + S_FW;
  localparam int PAD  = S_FW - H_FW;
  localparam int H_BIAS = (1 << (H_EW - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EW - 1)) - 1;
  localparam int REBIAS = S_BIAS - H_BIAS;
  localparam int SUB_BASE = S_BIAS - H_BIAS + 1;
  localparam int SH_W = $clog2(H_FW + 2);

  typedef logic [H_EW-1:0] hexp_t;
  typedef logic [H_FW-1:0] hfrac_t;
  typedef logic [S_EW-1:0] sexp_t;
  typedef logic [S_FW-1:0] sfrac_t;
  typedef logic [SH_W-1:0] shamt_t;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_NAN  = 3'd4
  } fclass_e;
endpackage

// File: rtl/hcvt_classify.sv
`timescale 1ns/1ps
module hcvt_classify
  import hcvt_pkg::*;
(
  input  logic [H_W-1:0] half_i,
  output logic           sign_o,
  output hexp_t          exp_o,
  output hfrac_t         frac_o,
  output fclass_e        cls_o
);
  logic exp_zero;
  logic exp_ones;
  logic frac_zero;

  always_comb begin
    sign_o    = half_i[H_W-1];
    exp_o     = half_i[H_W-2 -: H_EW];
    frac_o    = half_i[H_FW-1:0];
    exp_zero  = (exp_o == '0);
    exp_ones  = (exp_o == '1);
    frac_zero = (frac_o == '0);
    if (exp_zero) begin
      cls_o = frac_zero ? CL_ZERO : CL_SUB;
    end else if (exp_ones) begin
      cls_o = frac_zero ? CL_INF : CL_NAN;
    end else begin
      cls_o = CL_NORM;
    end
  end
endmodule

// File: rtl/hcvt_lzn.sv
`timescale 1ns/1ps
module hcvt_lzn #(
  parameter int W  = 10,
  parameter int SW = 4
) (
  input  logic [W-1:0]  frac_i,
  output logic [SW-1:0] shift_o,
  output logic [W-1:0]  frac_o
);
  localparam int STAGES = SW;

  logic [SW-1:0] lz;
  logic          found;
  logic [W-1:0]  stage [STAGES+1];

  // Priority encoder: leading zeros above the first set bit.
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (frac_i[i]) begin
          found = 1'b1;
        end else begin
          lz = lz + 1'b1;
        end
      end
    end
    shift_o = lz + 1'b1;
  end

  // Logarithmic barrel shifter; the leading one falls off the top.
  assign stage[0] = frac_i;
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int AMT = 1 << k;
      if (AMT < W) begin : g_shift
        assign stage[k+1] = shift_o[k] ? {stage[k][W-1-AMT:0], {AMT{1'b0}}} : stage[k];
      end else begin : g_clear
        assign stage[k+1] = shift_o[k] ? '0 : stage[k];
      end
    end
  endgenerate
  assign frac_o = stage[STAGES];
endmodule

// File: rtl/hcvt_assemble.sv
`timescale 1ns/1ps
module hcvt_assemble
  import hcvt_pkg::*;
(
  input  logic           sign_i,
  input  hexp_t          exp_i,
  input  hfrac_t         frac_i,
  input  fclass_e        cls_i,
  input  shamt_t         shift_i,
  input  hfrac_t         nfrac_i,
  output logic [S_W-1:0] word_o
);
  sexp_t  s_exp;
  sfrac_t s_frac;

  always_comb begin
    s_exp  = '0;
    s_frac = '0;
    unique case (cls_i)
      CL_ZERO: begin
        s_exp  = '0;
        s_frac = '0;
      end
      CL_SUB: begin
        s_exp  = sexp_t'(SUB_BASE) - sexp_t'(shift_i);
        s_frac = {nfrac_i, {PAD{1'b0}}};
      end
      CL_NORM: begin
        s_exp  = sexp_t'(exp_i) + sexp_t'(REBIAS);
        s_frac = {frac_i, {PAD{1'b0}}};
      end
      CL_INF: begin
        s_exp  = '1;
        s_frac = '0;
      end
      CL_NAN: begin
        s_exp  = '1;
        s_frac = {frac_i, {PAD{1'b1}}};
      end
      default: begin
        s_exp  = '0;
        s_frac = '0;
      end
    endcase
    word_o = {sign_i, s_exp, s_frac};
  end
endmodule

// File: rtl/hcvt_outstage.sv
`timescale 1ns/1ps
module hcvt_outstage #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic          valid_d, valid_q;
      logic [DW-1:0] data_d, data_q;
      logic          load_en;

      always_comb begin
        load_en = valid_i;
        valid_d = valid_i;
        data_d  = load_en ? data_i : data_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          data_q  <= '0;
        end else begin
          valid_q <= valid_d;
          data_q  <= data_d;
        end
      end

      assign valid_o = valid_q;
      assign data_o  = data_q;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o) else $error("valid lost"); // R7
      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o) else $error("spurious valid"); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(data_o)) else $error("result changed while idle"); // R8
    end else begin : g_pass
      assign valid_o = valid_i;
      assign data_o  = data_i;
    end
  endgenerate
endmodule

// File: rtl/half_to_single_widen.sv
`timescale 1ns/1ps
module half_to_single_widen
  import hcvt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  output logic        out_valid,
  output logic [31:0] out_single
);
  logic           h_sign;
  hexp_t          h_exp;
  hfrac_t         h_frac;
  fclass_e        h_cls;
  shamt_t         n_shift;
  hfrac_t         n_frac;
  logic [S_W-1:0] wide;

  hcvt_classify u_classify (
    .half_i (in_half),
    .sign_o (h_sign),
    .exp_o  (h_exp),
    .frac_o (h_frac),
    .cls_o  (h_cls)
  );

  hcvt_lzn #(.W(H_FW), .SW(SH_W)) u_lzn (
    .frac_i  (h_frac),
    .shift_o (n_shift),
    .frac_o  (n_frac)
  );

  hcvt_assemble u_assemble (
    .sign_i  (h_sign),
    .exp_i   (h_exp),
    .frac_i  (h_frac),
    .cls_i   (h_cls),
    .shift_i (n_shift),
    .nfrac_i (n_frac),
    .word_o  (wide)
  );

  hcvt_outstage #(.DW(S_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .data_i  (wide),
    .valid_o (out_valid),
    .data_o  (out_single)
  );

  AST_NORMAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:10] != 5'd0 && in_half[14:10] != 5'd31) |->
      (wide[22:13] == in_half[9:0] && wide[12:0] == 13'd0 &&
       wide[31] == in_half[15] && wide[30:23] == 8'(in_half[14:10]) + 8'd112))
    else $error("normal mapping"); // R1
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:0] == 15'd0) |-> (wide == {in_half[15], 31'd0}))
    else $error("zero mapping"); // R2
  AST_SUB_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:10] == 5'd0 && in_half[9:0] != 10'd0) |->
      (wide[30:23] >= 8'd103 && wide[30:23] <= 8'd112 && wide[12:0] == 13'd0))
    else $error("subnormal exponent range"); // R3
  AST_INF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:0] == 15'h7C00) |-> (wide[30:0] == 31'h7F800000))
    else $error("infinity mapping"); // R4
  AST_NAN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:10] == 5'd31 && in_half[9:0] != 10'd0) |->
      (wide[30:23] == 8'hFF && wide[12:0] == 13'h1FFF && wide[22:13] == in_half[9:0]))
    else $error("NaN padding"); // R5
endmodule

// File: tb/test_half_to_single_widen.sv
`timescale 1ns/1ps
module test_half_to_single_widen;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_half;
  logic        out_valid;
  logic [31:0] out_single;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [15:0] h;
    logic [31:0] w;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] last_word = 32'd0;

  half_to_single_widen i_half_to_single_widen (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference: real arithmetic for finite values (R6), bit rules for inf/NaN.
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    int  e;
    int  f;
    real m;
    int  ex;
    int  fr;
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 31) begin
      if (f == 0) return {h[15], 8'hFF, 23'd0};
      return {h[15], 8'hFF, h[9:0], 13'h1FFF};
    end
    if (e == 0 && f == 0) return {h[15], 31'd0};
    if (e == 0) m = real'(f) / 1024.0 * (2.0 ** -14);
    else        m = (1.0 + real'(f) / 1024.0) * (2.0 ** (e - 15));
    ex = 0;
    while (m >= 2.0) begin m = m / 2.0; ex++; end
    while (m < 1.0)  begin m = m * 2.0; ex--; end
    fr = $rtoi((m - 1.0) * 8388608.0);
    return {h[15], 8'(ex + 127), 23'(fr)};
  endfunction

  function automatic string req_of(input logic [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 10'd0) ? "R4" : "R5";
    if (h[14:10] == 5'd0)  return (h[9:0] == 10'd0) ? "R2" : "R3 R6";
    return "R1 R6";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [15:0] h);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    it.h = h;
    it.w = ref_widen(h);
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_half  = 16'hA5A5;
  endtask

  // Monitor: compare results after each edge (R7 latency, R8 hold).
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(out_valid == in_valid, "R7 valid", 32'(out_valid), 32'(in_valid));
      if (in_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", out_single, 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(out_single == it.w, req_of(it.h), out_single, it.w);
          last_word = it.w;
        end
      end else begin
        check(out_single == last_word, "R8 hold", out_single, last_word);
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_half  = 16'h0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0, "R7 reset valid", 32'(out_valid), 32'd0);
    check(out_single == 32'd0, "R7 reset data", out_single, 32'd0);
    rst_n = 1'b1;
    // Spot checks of hand-derived corner values through the scoreboard.
    drive(16'h0001);  // R3: smallest subnormal -> 2^-24 = 0x33800000
    drive(16'h03FF);  // R3: largest subnormal
    drive(16'h7C01);  // R5: NaN padding -> 0x7F803FFF
    idle();
    drive(16'h8000);  // R2: negative zero
    drive(16'hFC00);  // R4: negative infinity
    drive(16'h3C00);  // R1: 1.0 -> 0x3F800000
    idle();
    idle();
    for (int i = 0; i < 65536; i++) begin
      drive(16'(i));
      if ((i % 7) == 3) idle();
      if ((i % 61) == 5) begin idle(); idle(); end
    end
    idle();
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R7 all results delivered", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule